// File: doc/BRIEF.md
# Pin Bank Register Block with Analog Input Gating

This block is the register front end of an eight-pin general-purpose I/O bank. Software reaches it over a small register bus with a three-bit address, a write strobe, write data and combinational read data. It holds an output latch, a per-pin direction register, a per-pin analog-select register and one slew-rate control bit for the whole bank. It drives an output value, an output enable and the slew control to the pad logic.

Pin levels from the pads pass through a two-stage synchronizer. Each synchronized level is then gated by that pin's analog-select bit. A pin marked analog always reads 0 through the port address. Its output drive still follows the latch and the direction bit. After reset every pin is an analog input, and the slew control selects the reduced edge rate.

Port address accesses are asymmetric. A write goes to the latch, but a read returns the gated pin levels. A read-modify-write through the port address on an analog-selected output pin therefore reads 0 and clears that latch bit. The block keeps this behaviour rather than hiding it.

Top module: `pinbank_ctrl`

## Requirements
- R1: After reset the latch reads 0x00, the direction register reads 0xFF, the analog-select register reads 0xFF and the slew register reads 0x01. `pin_oe` is 0x00 and a port read returns 0x00 whatever the pins carry.
- R2: A write to address 0 (port) or address 1 (latch) loads the latch. The new value appears on `pin_out` and reads back from address 1 after that clock edge.
- R3: A read of address 0 returns, for each bit, the synchronized pin level AND NOT the analog-select bit. A pin whose analog-select bit is 1 reads 0.
- R4: A change on `pin_in` becomes visible in a port read after exactly two rising clock edges, and not after one.
- R5: `pin_oe` bit i is the inverse of direction bit i (direction 1 = input, 0 = output). The direction register is at address 2.
- R6: `pin_out` equals the latch whatever the analog-select register (address 3) holds.
- R7: Bit 0 of address 4 is the slew control (1 = reduced, 0 = standard) and drives `slew_reduced`. Bits 7:1 of address 4 read 0.
- R8: Addresses 5, 6 and 7 read 0x00, and writes to them change no register.
- R9: Reading address 0 and writing that value back clears the latch bit of every output pin whose analog-select bit is 1.
- R10: No register changes on a clock edge where `wr_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-on / brown-out) |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | 3 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `addr` |
| pin_in | input | 8 | Raw pin levels from the pads |
| pin_out | output | 8 | Output value to the pads (latch) |
| pin_oe | output | 8 | Per-pin output enable |
| slew_reduced | output | 1 | 1 selects the reduced slew rate |

## Verification
Register writes land on the rising edge where the strobe is high. The bench therefore drives a write at a falling edge, lets one rising edge pass, and reads or checks the outputs at the following falling edge. Reads are combinational, so each read is sampled one time step after the address is set. Pin changes need two rising edges before a port read shows them. The bench checks the old value after one edge and the new value after the second, and in the sweeps it waits three edges before comparing against pins AND NOT analog-select.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

    typedef enum logic [2:0] {
        AD_PORT  = 3'd0,
        AD_LATCH = 3'd1,
        AD_DIR   = 3'd2,
        AD_ANSEL = 3'd3,
        AD_SLEW  = 3'd4
    } pb_addr_e;

    localparam logic SLEW_RESET = 1'b1;

endpackage

// File: rtl/pinbank_regs.sv
module pinbank_regs #(
    parameter int W      = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wr_data,
    output logic [W-1:0]      latch_q,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      ansel_q,
    output logic              slew_q
);
    import pinbank_pkg::*;

    typedef struct packed {
        logic [W-1:0] latch;
        logic [W-1:0] dir;
        logic [W-1:0] ansel;
        logic         slew;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (addr)
                AD_PORT,
                AD_LATCH: r_d.latch = wr_data;
                AD_DIR:   r_d.dir   = wr_data;
                AD_ANSEL: r_d.ansel = wr_data;
                AD_SLEW:  r_d.slew  = wr_data[0];
                default:  r_d       = r_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.latch <= '0;
            r_q.dir   <= '1;
            r_q.ansel <= '1;
            r_q.slew  <= SLEW_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign latch_q = r_q.latch;
    assign dir_q   = r_q.dir;
    assign ansel_q = r_q.ansel;
    assign slew_q  = r_q.slew;

endmodule

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_sync
);
    logic [STAGES-1:0][W-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = pin_in;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign pin_sync = stage_q[STAGES-1];

endmodule

// File: rtl/pinbank_rdmux.sv
module pinbank_rdmux #(
    parameter int W      = 8,
    parameter int ADDR_W = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      pin_sync,
    input  logic [W-1:0]      latch_q,
    input  logic [W-1:0]      dir_q,
    input  logic [W-1:0]      ansel_q,
    input  logic              slew_q,
    output logic [W-1:0]      rd_data
);
    import pinbank_pkg::*;

    logic [W-1:0] gated;

    for (genvar i = 0; i < W; i++) begin : g_gate
        assign gated[i] = pin_sync[i] & ~ansel_q[i];
    end

    always_comb begin
        rd_data = '0;
        case (addr)
            AD_PORT:  rd_data = gated;
            AD_LATCH: rd_data = latch_q;
            AD_DIR:   rd_data = dir_q;
            AD_ANSEL: rd_data = ansel_q;
            AD_SLEW:  rd_data[0] = slew_q;
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl #(
    parameter int W      = 8,
    parameter int ADDR_W = 3,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wr_data,
    output logic [W-1:0]      rd_data,
    input  logic [W-1:0]      pin_in,
    output logic [W-1:0]      pin_out,
    output logic [W-1:0]      pin_oe,
    output logic              slew_reduced
);
    logic [W-1:0] latch_q, dir_q, ansel_q, pin_sync;
    logic         slew_q;

    pinbank_regs #(.W(W), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .latch_q (latch_q),
        .dir_q   (dir_q),
        .ansel_q (ansel_q),
        .slew_q  (slew_q)
    );

    pinbank_sync #(.W(W), .STAGES(STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .pin_sync (pin_sync)
    );

    pinbank_rdmux #(.W(W), .ADDR_W(ADDR_W)) u_rdmux (
        .addr     (addr),
        .pin_sync (pin_sync),
        .latch_q  (latch_q),
        .dir_q    (dir_q),
        .ansel_q  (ansel_q),
        .slew_q   (slew_q),
        .rd_data  (rd_data)
    );

    for (genvar i = 0; i < W; i++) begin : g_pad
        assign pin_out[i] = latch_q[i];
        assign pin_oe[i]  = ~dir_q[i];
    end

    assign slew_reduced = slew_q;

endmodule

// File: rtl/pinbank_chk.sv
module pinbank_chk #(
    parameter int W      = 8,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [W-1:0]      wr_data,
    input logic [W-1:0]      rd_data,
    input logic [W-1:0]      pin_out,
    input logic [W-1:0]      pin_oe,
    input logic              slew_reduced,
    input logic [W-1:0]      ansel_q
);
    assert_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe == '0 && pin_out == '0 && slew_reduced));

    assert_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == 3'd0 || addr == 3'd1)) |=> (pin_out == $past(wr_data)));

    assert_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 3'd0) |-> ((rd_data & ansel_q) == '0));

    assert_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd2) |=> (pin_oe == ~$past(wr_data)));

    assert_slew_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 3'd4) |-> (rd_data[W-1:1] == '0 && rd_data[0] == slew_reduced));

    assert_unused_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (addr > 3'd4) |-> (rd_data == '0));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(pin_out) && $stable(pin_oe) && $stable(slew_reduced)));

endmodule

bind pinbank_ctrl pinbank_chk #(.W(W), .ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .addr         (addr),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .pin_out      (pin_out),
    .pin_oe       (pin_oe),
    .slew_reduced (slew_reduced),
    .ansel_q      (ansel_q)
);

// File: tb/pinbank_ctrl_test.sv
module pinbank_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic [7:0] pin_in = 8'hFF;
    logic [7:0] pin_out, pin_oe;
    logic       slew_reduced;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pinbank_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .slew_reduced(slew_reduced)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        idle(3);
        rst_n = 1'b1;
        idle(3);

        // R1 reset state (pins held high throughout)
        rd(3'd1, v); check("R1 latch", v, 8'h00);
        rd(3'd2, v); check("R1 dir", v, 8'hFF);
        rd(3'd3, v); check("R1 ansel", v, 8'hFF);
        rd(3'd4, v); check("R1 slew", v, 8'h01);
        check("R1 oe", pin_oe, 8'h00);
        check("R1 slew pin", {7'd0, slew_reduced}, 8'h01);
        rd(3'd0, v); check("R1 port", v, 8'h00);

        // R2 / R6: latch sweep through both addresses, analog-select all set
        for (int d = 0; d < 256; d++) begin
            wr((d % 2 == 0) ? 3'd0 : 3'd1, 8'(d));
            check("R2 R6 pin_out", pin_out, 8'(d));
            rd(3'd1, v); check("R2 latch readback", v, 8'(d));
        end

        // R5: direction sweep
        for (int d = 0; d < 256; d++) begin
            wr(3'd2, 8'(d));
            check("R5 oe", pin_oe, ~8'(d));
            rd(3'd2, v); check("R5 dir readback", v, 8'(d));
        end

        // R3: pins x analog-select sweep
        for (int p = 0; p < 16; p++) begin
            @(negedge clk);
            pin_in = 8'(p * 17) ^ 8'h3C;
            idle(3);
            for (int a = 0; a < 256; a++) begin
                wr(3'd3, 8'(a));
                rd(3'd0, v); check("R3 gated port", v, pin_in & ~8'(a));
            end
        end

        // R4: two-edge latency
        wr(3'd3, 8'h00);
        @(negedge clk); pin_in = 8'h00;
        idle(3);
        @(negedge clk); pin_in = 8'hA5;
        @(negedge clk);
        rd(3'd0, v); check("R4 one edge", v, 8'h00);
        @(negedge clk);
        rd(3'd0, v); check("R4 two edges", v, 8'hA5);

        // R7: slew control
        wr(3'd4, 8'hFE);
        check("R7 standard", {7'd0, slew_reduced}, 8'h00);
        rd(3'd4, v); check("R7 readback", v, 8'h00);
        wr(3'd4, 8'hFF);
        check("R7 reduced", {7'd0, slew_reduced}, 8'h01);
        rd(3'd4, v); check("R7 upper bits", v, 8'h01);

        // R8: unused addresses
        wr(3'd1, 8'h5A); wr(3'd2, 8'hC3); wr(3'd3, 8'h96);
        for (int a = 5; a < 8; a++) begin
            wr(3'(a), 8'hFF);
            rd(3'(a), v); check("R8 unused read", v, 8'h00);
        end
        rd(3'd1, v); check("R8 latch kept", v, 8'h5A);
        rd(3'd2, v); check("R8 dir kept", v, 8'hC3);
        rd(3'd3, v); check("R8 ansel kept", v, 8'h96);
        rd(3'd4, v); check("R8 slew kept", v, 8'h01);

        // R10: no write without strobe
        @(negedge clk);
        addr = 3'd2; wr_data = 8'h00; wr_en = 1'b0;
        @(negedge clk);
        rd(3'd2, v); check("R10 dir held", v, 8'hC3);
        check("R10 oe held", pin_oe, 8'h3C);
        addr = 3'd1;
        @(negedge clk);
        check("R10 pin_out held", pin_out, 8'h5A);

        // R9: read-modify-write clears analog output bits
        wr(3'd2, 8'h00);
        wr(3'd3, 8'h0F);
        wr(3'd1, 8'hFF);
        @(negedge clk); pin_in = pin_out;
        idle(3);
        rd(3'd0, v); check("R9 port read", v, 8'hF0);
        wr(3'd0, v);
        check("R9 latch cleared", pin_out, 8'hF0);
        check("R9 oe still on", pin_oe, 8'hFF);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule